// File: doc/BRIEF.md
# Monochrome CRT Drive Timing Generator

This block drives a bare monochrome CRT monitor on the bench. The monitor has no oscillators of its own, so it needs separate horizontal-drive, vertical-drive and serial video signals. Every timing step is one period of a 1 MHz tick-enable input. A line is 64 ticks long and a frame is 260 lines with no interlace, which gives a 15.625 kHz line rate and a frame rate of about 60.096 Hz. The frame has four parts: 20 retrace lines with the vertical drive low, 20 dark lines, 200 picture lines, and 20 dark lines at the bottom.

Within a picture line the horizontal drive is a positive pulse that starts 5 ticks after the line begins. The 40-cell video window opens 18 ticks after that rising edge. Each cell is one tick long and is shifted out as 8 pixels, MSB first. A built-in test pattern supplies the cell contents: a one-cell border around the picture, plus half-cell bars on every fourth column. The block also exposes an active-picture flag and the current column and row indices. No light ever reaches the screen during either retrace or on the dark lines.

All registered outputs change only in the clock that follows a tick. They show the scan position that was current when that tick arrived.

Top module: `crt_drive_gen`

## Requirements
- R1: During and after reset, until the first tick, hdrive_o is 0, vdrive_o is 1, video_o is 0, active_o is 0, and col_o and row_o are 0.
- R2: A line is 64 ticks. hdrive_o is high for exactly 24 consecutive ticks, from line position 5 to line position 28, and low for the other 40 ticks.
- R3: A frame is 260 lines (16,640 ticks). vdrive_o is low for the first 20 lines of each frame (1,280 ticks) and high for the rest.
- R4: active_o is high for whole lines 40 to 239 of the frame (200 lines) and low on all other lines.
- R5: On an active line, the video window covers line positions 23 to 62. That is 40 ticks starting 18 ticks after the hdrive_o rising edge. In the window, col_o counts 0 to 39 and row_o gives the active line number 0 to 199. Outside the window col_o is 0, and off the active lines row_o is 0.
- R6: The first lit video pixel of a frame appears 1,303 ticks after vdrive_o rises.
- R7: A cell is 8 pixels, sent MSB first, each lasting CLKS_PER_PIX clocks. A cell in column 0, column 39, row 0 or row 199 has pattern 8'hFF. Any other cell whose column is a multiple of 4 has pattern 8'hF0. All remaining cells have pattern 8'h00.
- R8: video_o is 0 at every instant outside the video window: during horizontal retrace, vertical retrace and the dark top and bottom lines.
- R9: hdrive_o, vdrive_o, active_o, col_o and row_o change only in the clock that follows a clock with tick_i high. Each reflects the scan position held when that tick arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-clock timing enable, one per microsecond |
| hdrive_o | output | 1 | Horizontal drive, active high |
| vdrive_o | output | 1 | Vertical drive, active low |
| video_o | output | 1 | Serial pixel output, 1 = lit |
| active_o | output | 1 | High on picture lines |
| col_o | output | 6 | Cell column index within the video window |
| row_o | output | 8 | Picture line index |

## Verification
The bench runs the tick input at eight clocks per tick and the pixel rate at one per clock, and follows it through more than a full frame. The scoreboard sees every line type: retrace, the dark top and bottom lines, and the picture lines. Within the picture lines it sees the border rows, bar columns and plain cells. These separate errors in the line count, the frame split and the pattern selection. Holding the tick low right after reset shows that the outputs wait for it. Comparing each of the eight pixels per cell tells the MSB-first order and the half-cell bars apart from a whole-cell pattern. Measuring from tick to tick the vertical-drive low time, the frame period and the distance to the first lit pixel checks the frame-level offsets.

// File: rtl/crt_drive_pkg.sv
package crt_drive_pkg;

   typedef struct packed {
      logic hdrive;
      logic vdrive;
      logic active;
      logic window;
   } scan_flags_t;

   localparam int unsigned CELL_PIX = 8;

   typedef logic [CELL_PIX-1:0] cell_bits_t;

   localparam scan_flags_t FLAGS_IDLE = '{hdrive: 1'b0, vdrive: 1'b1,
                                          active: 1'b0, window: 1'b0};

   function automatic int unsigned width_of(input int unsigned span);
      return (span <= 1) ? 1 : $clog2(span);
   endfunction

endpackage

// File: rtl/crt_scan_counter.sv
module crt_scan_counter #(
   parameter int unsigned H_TOTAL = 64,
   parameter int unsigned V_TOTAL = 260,
   parameter int unsigned HW      = 6,
   parameter int unsigned VW      = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   output logic [HW-1:0] hcnt_o,
   output logic [VW-1:0] vcnt_o
);

   localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
   localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);

   logic h_wrap;
   logic v_wrap;

   assign h_wrap = (hcnt_o == H_LAST);
   assign v_wrap = (vcnt_o == V_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hcnt_o <= '0;
         vcnt_o <= '0;
      end else if (tick_i) begin
         if (h_wrap) begin
            hcnt_o <= '0;
            vcnt_o <= v_wrap ? '0 : vcnt_o + 1'b1;
         end else begin
            hcnt_o <= hcnt_o + 1'b1;
         end
      end
   end

endmodule

// File: rtl/crt_region_decode.sv
module crt_region_decode
   import crt_drive_pkg::*;
#(
   parameter int unsigned H_PULSE_START = 5,
   parameter int unsigned H_PULSE_LEN   = 24,
   parameter int unsigned VID_DELAY     = 18,
   parameter int unsigned COLS          = 40,
   parameter int unsigned V_RETRACE     = 20,
   parameter int unsigned V_TOP         = 20,
   parameter int unsigned ROWS          = 200,
   parameter int unsigned HW            = 6,
   parameter int unsigned VW            = 9,
   parameter int unsigned CW            = 6,
   parameter int unsigned RW            = 8
) (
   input  logic [HW-1:0] hcnt_i,
   input  logic [VW-1:0] vcnt_i,
   output scan_flags_t   flags_o,
   output logic [CW-1:0] col_o,
   output logic [RW-1:0] row_o
);

   localparam int unsigned WIN_START = H_PULSE_START + VID_DELAY;
   localparam int unsigned ACT_START = V_RETRACE + V_TOP;

   localparam logic [HW-1:0] HD_FIRST  = HW'(H_PULSE_START);
   localparam logic [HW-1:0] HD_LAST   = HW'(H_PULSE_START + H_PULSE_LEN - 1);
   localparam logic [HW-1:0] WIN_FIRST = HW'(WIN_START);
   localparam logic [HW-1:0] WIN_LAST  = HW'(WIN_START + COLS - 1);
   localparam logic [VW-1:0] RET_LAST  = VW'(V_RETRACE - 1);
   localparam logic [VW-1:0] ACT_FIRST = VW'(ACT_START);
   localparam logic [VW-1:0] ACT_LAST  = VW'(ACT_START + ROWS - 1);

   logic in_hd;
   logic in_ret;
   logic in_act;
   logic in_win;

   always_comb begin
      in_hd  = (hcnt_i >= HD_FIRST) && (hcnt_i <= HD_LAST);
      in_ret = (vcnt_i <= RET_LAST);
      in_act = (vcnt_i >= ACT_FIRST) && (vcnt_i <= ACT_LAST);
      in_win = in_act && (hcnt_i >= WIN_FIRST) && (hcnt_i <= WIN_LAST);

      flags_o.hdrive = in_hd;
      flags_o.vdrive = ~in_ret;
      flags_o.active = in_act;
      flags_o.window = in_win;

      col_o = in_win ? CW'(hcnt_i - WIN_FIRST) : '0;
      row_o = in_act ? RW'(vcnt_i - ACT_FIRST) : '0;
   end

endmodule

// File: rtl/crt_cell_pattern.sv
module crt_cell_pattern
   import crt_drive_pkg::*;
#(
   parameter int unsigned COLS        = 40,
   parameter int unsigned ROWS        = 200,
   parameter int unsigned BAR_PITCH   = 4,
   parameter cell_bits_t  BORDER_BITS = 8'hFF,
   parameter cell_bits_t  BAR_BITS    = 8'hF0,
   parameter int unsigned CW          = 6,
   parameter int unsigned RW          = 8
) (
   input  logic          window_i,
   input  logic [CW-1:0] col_i,
   input  logic [RW-1:0] row_i,
   output cell_bits_t    bits_o
);

   localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);
   localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);

   logic on_bar;
   logic on_border;

   generate
      if (BAR_PITCH == 1) begin : g_bar_every
         assign on_bar = 1'b1;
      end else if ((BAR_PITCH & (BAR_PITCH - 1)) == 0) begin : g_bar_mask
         localparam int unsigned MW = $clog2(BAR_PITCH);
         assign on_bar = (col_i[MW-1:0] == '0);
      end else begin : g_bar_mod
         assign on_bar = ((32'(col_i) % BAR_PITCH) == 0);
      end
   endgenerate

   assign on_border = (col_i == '0) || (col_i == COL_LAST) ||
                      (row_i == '0) || (row_i == ROW_LAST);

   always_comb begin
      if (!window_i)      bits_o = '0;
      else if (on_border) bits_o = BORDER_BITS;
      else if (on_bar)    bits_o = BAR_BITS;
      else                bits_o = '0;
   end

endmodule

// File: rtl/crt_pixel_serializer.sv
module crt_pixel_serializer
   import crt_drive_pkg::*;
#(
   parameter int unsigned CLKS_PER_PIX = 25
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  cell_bits_t load_i,
   output logic       pix_o
);

   logic       shift_en;
   cell_bits_t sh_q;

   generate
      if (CLKS_PER_PIX == 1) begin : g_pix_every_clk
         assign shift_en = 1'b1;
      end else begin : g_pix_divider
         localparam int unsigned DW = width_of(CLKS_PER_PIX);
         localparam logic [DW-1:0] DIV_LAST = DW'(CLKS_PER_PIX - 1);
         logic [DW-1:0] div_q;
         always_ff @(posedge clk) begin
            if (!rst_n || tick_i)       div_q <= '0;
            else if (div_q == DIV_LAST) div_q <= '0;
            else                        div_q <= div_q + 1'b1;
         end
         assign shift_en = (div_q == DIV_LAST);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)        sh_q <= '0;
      else if (tick_i)   sh_q <= load_i;
      else if (shift_en) sh_q <= {sh_q[CELL_PIX-2:0], 1'b0};
   end

   assign pix_o = sh_q[CELL_PIX-1];

endmodule

// File: rtl/crt_drive_gen.sv
module crt_drive_gen
   import crt_drive_pkg::*;
#(
   parameter int unsigned H_TOTAL       = 64,
   parameter int unsigned H_PULSE_START = 5,
   parameter int unsigned H_PULSE_LEN   = 24,
   parameter int unsigned VID_DELAY     = 18,
   parameter int unsigned COLS          = 40,
   parameter int unsigned V_RETRACE     = 20,
   parameter int unsigned V_TOP         = 20,
   parameter int unsigned ROWS          = 200,
   parameter int unsigned V_BOTTOM      = 20,
   parameter int unsigned BAR_PITCH     = 4,
   parameter int unsigned CLKS_PER_PIX  = 25
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              tick_i,
   output logic                              hdrive_o,
   output logic                              vdrive_o,
   output logic                              video_o,
   output logic                              active_o,
   output logic [crt_drive_pkg::width_of(COLS)-1:0] col_o,
   output logic [crt_drive_pkg::width_of(ROWS)-1:0] row_o
);

   localparam int unsigned V_TOTAL = V_RETRACE + V_TOP + ROWS + V_BOTTOM;
   localparam int unsigned HW      = width_of(H_TOTAL);
   localparam int unsigned VW      = width_of(V_TOTAL);
   localparam int unsigned COL_W   = width_of(COLS);
   localparam int unsigned ROW_W   = width_of(ROWS);

   generate
      if (H_PULSE_START + VID_DELAY + COLS > H_TOTAL) begin : g_bad_hwin
         $error("video window runs past the end of the line");
      end
      if (H_PULSE_START + H_PULSE_LEN > H_TOTAL) begin : g_bad_hpulse
         $error("horizontal drive pulse runs past the end of the line");
      end
      if (V_RETRACE == 0 || ROWS == 0 || COLS == 0) begin : g_bad_zero
         $error("retrace, row and column counts must be non-zero");
      end
      if (CLKS_PER_PIX == 0) begin : g_bad_pix
         $error("pixel divider must be at least one");
      end
   endgenerate

   logic [HW-1:0]    hcnt;
   logic [VW-1:0]    vcnt;
   scan_flags_t      flags_d;
   scan_flags_t      flags_q;
   logic [COL_W-1:0] col_d;
   logic [ROW_W-1:0] row_d;
   cell_bits_t       cell_bits;
   logic             pix;

   crt_scan_counter #(
      .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .HW(HW), .VW(VW)
   ) u_scan (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
      .hcnt_o(hcnt), .vcnt_o(vcnt)
   );

   crt_region_decode #(
      .H_PULSE_START(H_PULSE_START), .H_PULSE_LEN(H_PULSE_LEN),
      .VID_DELAY(VID_DELAY), .COLS(COLS), .V_RETRACE(V_RETRACE),
      .V_TOP(V_TOP), .ROWS(ROWS), .HW(HW), .VW(VW),
      .CW(COL_W), .RW(ROW_W)
   ) u_decode (
      .hcnt_i(hcnt), .vcnt_i(vcnt),
      .flags_o(flags_d), .col_o(col_d), .row_o(row_d)
   );

   crt_cell_pattern #(
      .COLS(COLS), .ROWS(ROWS), .BAR_PITCH(BAR_PITCH),
      .BORDER_BITS(8'hFF), .BAR_BITS(8'hF0), .CW(COL_W), .RW(ROW_W)
   ) u_pattern (
      .window_i(flags_d.window), .col_i(col_d), .row_i(row_d),
      .bits_o(cell_bits)
   );

   crt_pixel_serializer #(
      .CLKS_PER_PIX(CLKS_PER_PIX)
   ) u_serial (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
      .load_i(cell_bits), .pix_o(pix)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_q <= FLAGS_IDLE;
         col_o   <= '0;
         row_o   <= '0;
      end else if (tick_i) begin
         flags_q <= flags_d;
         col_o   <= col_d;
         row_o   <= row_d;
      end
   end

   assign hdrive_o = flags_q.hdrive;
   assign vdrive_o = flags_q.vdrive;
   assign active_o = flags_q.active;
   assign video_o  = pix & flags_q.window;

endmodule

// File: rtl/crt_drive_gen_chk.sv
module crt_drive_gen_chk #(
   parameter int unsigned H_PULSE_LEN = 24,
   parameter int unsigned COLS        = 40,
   parameter int unsigned CW          = 6,
   parameter int unsigned RW          = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tick_i,
   input logic          hdrive_o,
   input logic          vdrive_o,
   input logic          video_o,
   input logic          active_o,
   input logic [CW-1:0] col_o,
   input logic [RW-1:0] row_o
);

   logic        past_ok;
   int unsigned hd_ticks;

   always_ff @(posedge clk) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !hdrive_o) hd_ticks <= 0;
      else if (tick_i)         hd_ticks <= hd_ticks + 1;
   end

   AST_HDRIVE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hdrive_o) |-> (hd_ticks == H_PULSE_LEN)); // R2

   AST_ACTIVE_OUTSIDE_RETRACE: assert property (@(posedge clk) disable iff (!rst_n)
      active_o |-> vdrive_o); // R4

   AST_VIDEO_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      video_o |-> active_o); // R8

   AST_COL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(col_o) < COLS)); // R5

   AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(tick_i)) |->
         ($stable(hdrive_o) && $stable(vdrive_o) && $stable(active_o) &&
          $stable(col_o) && $stable(row_o))); // R9

endmodule

bind crt_drive_gen crt_drive_gen_chk #(
   .H_PULSE_LEN(H_PULSE_LEN), .COLS(COLS), .CW(COL_W), .RW(ROW_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .hdrive_o(hdrive_o),
   .vdrive_o(vdrive_o), .video_o(video_o), .active_o(active_o),
   .col_o(col_o), .row_o(row_o)
);

// File: tb/crt_drive_gen_tb.sv
`timescale 1ns/1ps
module crt_drive_gen_tb;

   localparam int TICK_CLKS = 8;
   localparam int RUN_TICKS = 16640 + 200;

   typedef struct {
      bit       hd;
      bit       vd;
      bit       act;
      bit       win;
      int       col;
      int       row;
      bit [7:0] bits;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic       hdrive_o, vdrive_o, video_o, active_o;
   logic [5:0] col_o;
   logic [7:0] row_o;

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   exp_t q[$];
   exp_t cur;
   bit   have_cur = 0;
   int   pix = 7;
   logic tick_seen = 1'b0;
   int   tick_idx = 0;
   int   h_m = 0;
   int   v_m = 0;

   bit   prev_vd = 1'b1;
   int   vd_fall[$];
   int   vd_rise_tick = -1;
   int   first_vid_tick = -1;

   always #2.5 clk = ~clk;

   crt_drive_gen #(.CLKS_PER_PIX(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .hdrive_o(hdrive_o),
      .vdrive_o(vdrive_o), .video_o(video_o), .active_o(active_o),
      .col_o(col_o), .row_o(row_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d (tick %0d)", req, act, exp, tick_idx);
      end
   endtask

   function automatic exp_t model(input int h, input int v);
      exp_t e;
      e.hd   = (h >= 5) && (h <= 28);
      e.vd   = (v >= 20);
      e.act  = (v >= 40) && (v <= 239);
      e.win  = e.act && (h >= 23) && (h <= 62);
      e.col  = e.win ? h - 23 : 0;
      e.row  = e.act ? v - 40 : 0;
      if (!e.win) e.bits = 8'h00;
      else if (e.col == 0 || e.col == 39 || e.row == 0 || e.row == 199) e.bits = 8'hFF;
      else if (e.col % 4 == 0) e.bits = 8'hF0;
      else e.bits = 8'h00;
      return e;
   endfunction

   // driver: one tick per call, expected result pushed into the scoreboard
   task automatic drive_tick();
      @(negedge clk);
      tick_i = 1'b1;
      q.push_back(model(h_m, v_m));
      if (h_m == 63) begin
         h_m = 0;
         v_m = (v_m == 259) ? 0 : v_m + 1;
      end else begin
         h_m = h_m + 1;
      end
      @(negedge clk);
      tick_i = 1'b0;
      repeat (TICK_CLKS - 2) @(negedge clk);
   endtask

   always @(posedge clk) tick_seen <= tick_i;

   // monitor: pops one item per tick and follows its eight pixels
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (tick_seen && q.size() > 0) begin
            cur = q.pop_front();
            have_cur = 1;
            pix = 0;
            tick_idx++;
            chk("R2 hdrive", int'(hdrive_o), int'(cur.hd));
            chk("R3 vdrive", int'(vdrive_o), int'(cur.vd));
            chk("R4 active", int'(active_o), int'(cur.act));
            chk("R5 col", int'(col_o), cur.col);
            chk("R5 row", int'(row_o), cur.row);
            chk(cur.win ? "R7 pixel" : "R8 blank", int'(video_o), int'(cur.bits[7]));
            if (prev_vd && !vdrive_o) vd_fall.push_back(tick_idx);
            if (!prev_vd && vdrive_o && vd_rise_tick < 0) vd_rise_tick = tick_idx;
            if (video_o && first_vid_tick < 0 && vd_rise_tick >= 0) first_vid_tick = tick_idx;
            prev_vd = vdrive_o;
         end else if (have_cur && pix < 7) begin
            pix++;
            chk(cur.win ? "R7 pixel" : "R8 blank", int'(video_o), int'(cur.bits[7-pix]));
            chk("R9 hold hdrive", int'(hdrive_o), int'(cur.hd));
            chk("R9 hold active", int'(active_o), int'(cur.act));
         end
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      chk("R1 hdrive in reset", int'(hdrive_o), 0);
      chk("R1 vdrive in reset", int'(vdrive_o), 1);
      chk("R1 video in reset", int'(video_o), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk("R1 hdrive", int'(hdrive_o), 0);
      chk("R1 vdrive", int'(vdrive_o), 1);
      chk("R1 video", int'(video_o), 0);
      chk("R1 active", int'(active_o), 0);
      chk("R1 col", int'(col_o), 0);
      chk("R1 row", int'(row_o), 0);
      for (int i = 0; i < RUN_TICKS; i++) drive_tick();
      repeat (4) @(negedge clk);
      chk("R3 vdrive falls twice", vd_fall.size(), 2);
      if (vd_fall.size() >= 2) chk("R3 frame period", vd_fall[1] - vd_fall[0], 16640);
      if (vd_fall.size() >= 1) chk("R3 vdrive low time", vd_rise_tick - vd_fall[0], 1280);
      chk("R6 first video after vdrive rise", first_vid_tick - vd_rise_tick, 1303);
      finish_run();
   end

endmodule